// File: doc/BRIEF.md
# Selectable-Mapping LVDS Pixel Serializer

This block turns one parallel pixel per pixel period into seven serial slots on up to four data lanes. It also drives a clock lane that repeats a fixed seven-slot pattern. A pixel carries red, green and blue components of 8 bits each, plus horizontal sync, vertical sync and data enable. The block runs entirely on the fast slot clock, which is seven times the pixel rate. It samples the pixel word and the mapping selector once per frame, at the edge that begins slot 0.

A two-bit selector chooses one of three bit placements:

- an 18-bit layout on three lanes;
- a 24-bit layout on four lanes that puts the upper color bits on lanes 0 to 2;
- a 24-bit layout on four lanes that keeps lanes 0 to 2 identical to the 18-bit layout and adds the two most significant bits of each color on lane 3.

A lane-enable output tells the analog drivers which lanes carry data. The pixel source holds its word steady for at least the edge that starts a frame. The one-cycle frame strobe lets a downstream stage or a bench align to slot 0.

Top module: `lvds_pixel_serializer`

## Requirements
- R1: Each frame lasts exactly 7 clocks, slots 0 to 6. `frame_strobe_o` is high only while slot 0 is on the outputs, so it recurs every 7 clocks. The first strobe appears on the first rising edge after reset is released.
- R2: `clk_lane_o` is 1 in slots 0, 1, 5 and 6, and 0 in slots 2, 3 and 4.
- R3: Mode 2'd0 (18-bit) carries the following, each list from slot 0 to slot 6:
  - lane 0: G0 R5 R4 R3 R2 R1 R0
  - lane 1: B1 B0 G5 G4 G3 G2 G1
  - lane 2: DE VS HS B5 B4 B3 B2
- R4: Mode 2'd1 (24-bit, upper bits first) carries, from slot 0 to slot 6:
  - lane 0: G2 R7 R6 R5 R4 R3 R2
  - lane 1: B3 B2 G7 G6 G5 G4 G3
  - lane 2: DE VS HS B7 B6 B5 B4
  - lane 3: 0 B1 B0 G1 G0 R1 R0
- R5: Mode 2'd2 (24-bit, low bits first) carries the same lanes 0 to 2 as R3. Lane 3 carries 0 B7 B6 G7 G6 R7 R6, from slot 0 to slot 6.
- R6: Horizontal sync sits in slot 2 of lane 2, vertical sync in slot 1 and data enable in slot 0. Lane 3 is 0 in slot 0 in every mode.
- R7: `lane_en_o` (bit n = lane n) is 4'b0111 in 18-bit mode and 4'b1111 in both 24-bit modes. Lane 3 is held at 0 whenever its enable is low. The unused encoding 2'd3 behaves exactly like 2'd0.
- R8: Pixel inputs and the mode are sampled only at the edge that starts slot 0. Changes during slots 1 to 6 do not alter the frame in progress or `lane_en_o`, and they take effect from the next slot 0.
- R9: While `rst_ni` is low, every lane, the clock lane, the strobe and the lane enables are 0. Reset applied mid-frame abandons that frame. After release, output restarts at slot 0 with the pixel then present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Slot clock, seven times the pixel rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Mapping select: 0 = 18-bit, 1 = 24-bit upper-first, 2 = 24-bit low-first, 3 = as 0 |
| red_i | input | 8 | Red component |
| green_i | input | 8 | Green component |
| blue_i | input | 8 | Blue component |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync |
| de_i | input | 1 | Data enable |
| lane_o | output | 4 | Serial data, bit n = lane n |
| lane_en_o | output | 4 | Lane active flags, bit n = lane n |
| clk_lane_o | output | 1 | Seven-slot clock lane pattern |
| frame_strobe_o | output | 1 | High during slot 0 |

## Verification
The vector table switches among all four selector codes from frame to frame. This catches a design that samples the mode at the wrong time: it would send one frame with the old layout, or flip `lane_en_o` in mid-frame. Colors with distinct upper and lower bits separate the two 24-bit layouts, so that a mixed-up shift of the color fields or a reversed slot order shows up as bit errors on a named lane. Directed frames drive one sync or enable bit at a time, which exposes any swap of the control slots or a nonzero lane 3 in slot 0. The inputs are also changed in mid-frame, to catch a design that samples them on every slot. A reset in mid-frame checks that the slot counter restarts instead of resuming at the next slot.

// File: rtl/lvds_ser_pkg.sv
`timescale 1ns/1ps
package lvds_ser_pkg;
  localparam int unsigned SLOTS   = 7;
  localparam int unsigned LANES   = 4;
  localparam int unsigned COLOR_W = 8;
  localparam int unsigned SLOT_W  = $clog2(SLOTS);

  typedef enum logic [1:0] {
    MAP_J18  = 2'd0,
    MAP_J24  = 2'd1,
    MAP_V24  = 2'd2,
    MAP_RSVD = 2'd3
  } map_e;

  typedef logic [SLOTS-1:0] frame_t;

  typedef struct packed {
    logic [COLOR_W-1:0] r;
    logic [COLOR_W-1:0] g;
    logic [COLOR_W-1:0] b;
    logic               hs;
    logic               vs;
    logic               de;
  } pixel_t;

  // bit n = slot n
  localparam frame_t CLK_PATTERN = 7'b1100011;
endpackage

// File: rtl/lvds_slot_seq.sv
`timescale 1ns/1ps
module lvds_slot_seq
  import lvds_ser_pkg::*;
#(
  parameter int unsigned N_SLOTS = SLOTS
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic load_o,
  output logic clk_lane_o,
  output logic strobe_o
);
  localparam int unsigned CW = $clog2(N_SLOTS);
  localparam logic [CW-1:0] LAST = CW'(N_SLOTS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          clk_q, stb_q;

  assign load_o = (cnt_q == LAST);
  assign cnt_d  = load_o ? '0 : cnt_q + 1'b1;

  // reset parks on the last slot so the first edge after release loads slot 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= LAST;
      clk_q <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      clk_q <= CLK_PATTERN[cnt_d];
      stb_q <= load_o;
    end
  end

  assign clk_lane_o = clk_q;
  assign strobe_o   = stb_q;
endmodule

// File: rtl/lvds_bit_mapper.sv
`timescale 1ns/1ps
module lvds_bit_mapper
  import lvds_ser_pkg::*;
(
  input  map_e                        mode_i,
  input  pixel_t                      pix_i,
  output logic [LANES-1:0][SLOTS-1:0] frames_o,
  output logic [LANES-1:0]            en_o
);
  logic [5:0] r6, g6, b6;
  logic       wide_upper;

  assign wide_upper = (mode_i == MAP_J24);

  // upper-first layout reuses the 18-bit placement on bits [7:2]
  always_comb begin
    if (wide_upper) begin
      r6 = pix_i.r[7:2];
      g6 = pix_i.g[7:2];
      b6 = pix_i.b[7:2];
    end else begin
      r6 = pix_i.r[5:0];
      g6 = pix_i.g[5:0];
      b6 = pix_i.b[5:0];
    end
  end

  always_comb begin
    frames_o[0] = {r6[0], r6[1], r6[2], r6[3], r6[4], r6[5], g6[0]};
    frames_o[1] = {g6[1], g6[2], g6[3], g6[4], g6[5], b6[0], b6[1]};
    frames_o[2] = {b6[2], b6[3], b6[4], b6[5], pix_i.hs, pix_i.vs, pix_i.de};
    unique case (mode_i)
      MAP_J24: frames_o[3] = {pix_i.r[0], pix_i.r[1], pix_i.g[0], pix_i.g[1],
                              pix_i.b[0], pix_i.b[1], 1'b0};
      MAP_V24: frames_o[3] = {pix_i.r[6], pix_i.r[7], pix_i.g[6], pix_i.g[7],
                              pix_i.b[6], pix_i.b[7], 1'b0};
      default: frames_o[3] = '0;
    endcase
  end

  always_comb begin
    unique case (mode_i)
      MAP_J24, MAP_V24: en_o = 4'b1111;
      default:          en_o = 4'b0111;
    endcase
  end
endmodule

// File: rtl/lvds_lane_shift.sv
`timescale 1ns/1ps
module lvds_lane_shift
  import lvds_ser_pkg::*;
#(
  parameter int unsigned N_SLOTS = SLOTS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [N_SLOTS-1:0] frame_i,
  output logic               bit_o
);
  logic [N_SLOTS-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load_i) sh_q <= frame_i;
    else             sh_q <= sh_q >> 1;
  end

  assign bit_o = sh_q[0];
endmodule

// File: rtl/lvds_pixel_serializer.sv
`timescale 1ns/1ps
module lvds_pixel_serializer
  import lvds_ser_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         mode_i,
  input  logic [COLOR_W-1:0] red_i,
  input  logic [COLOR_W-1:0] green_i,
  input  logic [COLOR_W-1:0] blue_i,
  input  logic               hsync_i,
  input  logic               vsync_i,
  input  logic               de_i,
  output logic [LANES-1:0]   lane_o,
  output logic [LANES-1:0]   lane_en_o,
  output logic               clk_lane_o,
  output logic               frame_strobe_o
);
  pixel_t                      pix;
  logic                        load;
  logic [LANES-1:0][SLOTS-1:0] frames;
  logic [LANES-1:0]            en_d;
  logic [LANES-1:0]            en_q;

  assign pix = '{r: red_i, g: green_i, b: blue_i, hs: hsync_i, vs: vsync_i, de: de_i};

  lvds_slot_seq #(.N_SLOTS(SLOTS)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_o     (load),
    .clk_lane_o (clk_lane_o),
    .strobe_o   (frame_strobe_o)
  );

  lvds_bit_mapper u_map (
    .mode_i   (map_e'(mode_i)),
    .pix_i    (pix),
    .frames_o (frames),
    .en_o     (en_d)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lvds_lane_shift #(.N_SLOTS(SLOTS)) u_sh (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load),
      .frame_i (frames[l]),
      .bit_o   (lane_o[l])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (load) en_q <= en_d;
  end

  assign lane_en_o = en_q;
endmodule

// File: rtl/lvds_pixel_serializer_chk.sv
`timescale 1ns/1ps
module lvds_pixel_serializer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] lane_o,
  input logic [3:0] lane_en_o,
  input logic       clk_lane_o,
  input logic       frame_strobe_o
);
  AST_STROBE_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(frame_strobe_o, 7) |-> frame_strobe_o); // R1
  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_strobe_o |=> !frame_strobe_o); // R1
  AST_CLK_HIGH_S0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_strobe_o |-> clk_lane_o); // R2
  AST_CLK_LOW_S2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(frame_strobe_o, 2) |-> !clk_lane_o); // R2
  AST_CLK_HIGH_S5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(frame_strobe_o, 5) |-> clk_lane_o); // R2
  AST_CTL3_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_strobe_o |-> !lane_o[3]); // R6
  AST_LANE3_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lane_en_o[3] |-> !lane_o[3]); // R7
  AST_EN_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_strobe_o |-> $stable(lane_en_o)); // R8
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (lane_o == 4'b0 && lane_en_o == 4'b0 && !clk_lane_o && !frame_strobe_o)); // R9
endmodule

bind lvds_pixel_serializer lvds_pixel_serializer_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lane_o         (lane_o),
  .lane_en_o      (lane_en_o),
  .clk_lane_o     (clk_lane_o),
  .frame_strobe_o (frame_strobe_o)
);

// File: tb/lvds_pixel_serializer_tb.sv
`timescale 1ns/1ps
module lvds_pixel_serializer_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = '0;
  logic [7:0] red_i = '0, green_i = '0, blue_i = '0;
  logic       hsync_i = 1'b0, vsync_i = 1'b0, de_i = 1'b0;
  logic [3:0] lane_o, lane_en_o;
  logic       clk_lane_o, frame_strobe_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk_i = ~clk_i;

  lvds_pixel_serializer u_dut (
    .clk_i, .rst_ni, .mode_i, .red_i, .green_i, .blue_i,
    .hsync_i, .vsync_i, .de_i,
    .lane_o, .lane_en_o, .clk_lane_o, .frame_strobe_o
  );

  // vector: {mode[1:0], r[7:0], g[7:0], b[7:0], hs, vs, de}
  localparam int NV = 10;
  localparam logic [28:0] VEC [NV] = '{
    {2'd0, 8'hA5, 8'h3C, 8'h0F, 1'b1, 1'b0, 1'b1},
    {2'd1, 8'hA5, 8'h3C, 8'h0F, 1'b1, 1'b0, 1'b1},
    {2'd2, 8'hA5, 8'h3C, 8'h0F, 1'b1, 1'b0, 1'b1},
    {2'd2, 8'hC3, 8'h81, 8'h7E, 1'b0, 1'b1, 1'b0},
    {2'd1, 8'h0F, 8'hF0, 8'h96, 1'b0, 1'b1, 1'b1},
    {2'd0, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1},
    {2'd3, 8'h5A, 8'hC6, 8'h39, 1'b1, 1'b0, 1'b0},
    {2'd1, 8'h01, 8'h80, 8'h40, 1'b0, 1'b0, 1'b1},
    {2'd2, 8'h3F, 8'hC0, 8'hE1, 1'b1, 1'b1, 1'b0},
    {2'd0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0}
  };

  // expected lane contents, slot 0 in bit 6
  function automatic logic [6:0] exp_lane(input logic [28:0] v, input int l);
    logic [1:0] m = v[28:27];
    logic [7:0] r = v[26:19], g = v[18:11], b = v[10:3];
    logic hs = v[2], vs = v[1], de = v[0];
    if (m == 2'd1) begin
      case (l)
        0: return {g[2], r[7], r[6], r[5], r[4], r[3], r[2]};
        1: return {b[3], b[2], g[7], g[6], g[5], g[4], g[3]};
        2: return {de, vs, hs, b[7], b[6], b[5], b[4]};
        default: return {1'b0, b[1], b[0], g[1], g[0], r[1], r[0]};
      endcase
    end
    case (l)
      0: return {g[0], r[5], r[4], r[3], r[2], r[1], r[0]};
      1: return {b[1], b[0], g[5], g[4], g[3], g[2], g[1]};
      2: return {de, vs, hs, b[5], b[4], b[3], b[2]};
      default: return (m == 2'd2) ? {1'b0, b[7], b[6], g[7], g[6], r[7], r[6]} : 7'b0;
    endcase
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic apply(input logic [28:0] v);
    {mode_i, red_i, green_i, blue_i, hsync_i, vsync_i, de_i} = v;
  endtask

  // called at a negedge with v on the inputs; ends at the negedge after slot 6
  task automatic run_frame(input logic [28:0] v, input string tag,
                           input bit pert, input logic [28:0] pv);
    logic [3:0] exp_d;
    logic [3:0] exp_en;
    exp_en = (v[28:27] == 2'd1 || v[28:27] == 2'd2) ? 4'hF : 4'h7;
    for (int s = 0; s < 7; s++) begin
      @(negedge clk_i);
      for (int l = 0; l < 4; l++) exp_d[l] = exp_lane(v, l)[6-s];
      check(tag, {4'h0, lane_o}, {4'h0, exp_d});
      check("R2", {7'h0, clk_lane_o}, {7'h0, (s < 2 || s > 4)});
      check("R1", {7'h0, frame_strobe_o}, {7'h0, (s == 0)});
      check(pert ? "R8" : "R7", {4'h0, lane_en_o}, {4'h0, exp_en});
      if (pert && s == 0) apply(pv);
    end
  endtask

  initial begin
    #500us;
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk_i);
    // R9: quiet while in reset
    check("R9", {lane_en_o, lane_o}, 8'h00);
    check("R9", {6'h0, clk_lane_o, frame_strobe_o}, 8'h00);
    apply(VEC[0]);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      run_frame(VEC[i], mode_tag(VEC[i][28:27]), 1'b0, '0);
    end

    // R6: one control bit at a time
    apply({2'd1, 24'h0, 1'b1, 1'b0, 1'b0});
    run_frame({2'd1, 24'h0, 1'b1, 1'b0, 1'b0}, "R6", 1'b0, '0);
    apply({2'd2, 24'h0, 1'b0, 1'b1, 1'b0});
    run_frame({2'd2, 24'h0, 1'b0, 1'b1, 1'b0}, "R6", 1'b0, '0);
    apply({2'd0, 24'hFFFFFF, 1'b0, 1'b0, 1'b1});
    run_frame({2'd0, 24'hFFFFFF, 1'b0, 1'b0, 1'b1}, "R6", 1'b0, '0);

    // R8: inputs and mode change mid-frame, seen only from next slot 0
    apply({2'd2, 8'hE7, 8'h18, 8'hC3, 1'b1, 1'b1, 1'b1});
    run_frame({2'd2, 8'hE7, 8'h18, 8'hC3, 1'b1, 1'b1, 1'b1}, "R8", 1'b1,
              {2'd0, 8'h18, 8'hE7, 8'h3C, 1'b0, 1'b0, 1'b0});
    run_frame({2'd0, 8'h18, 8'hE7, 8'h3C, 1'b0, 1'b0, 1'b0}, "R8", 1'b0, '0);

    // R9: reset mid-frame, then restart at slot 0
    apply({2'd1, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1});
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R9", {lane_en_o, lane_o}, 8'h00);
    check("R9", {6'h0, clk_lane_o, frame_strobe_o}, 8'h00);
    repeat (8) @(negedge clk_i);
    apply({2'd2, 8'h96, 8'h69, 8'hA5, 1'b0, 1'b1, 1'b1});
    rst_ni = 1'b1;
    run_frame({2'd2, 8'h96, 8'h69, 8'hA5, 1'b0, 1'b1, 1'b1}, "R9", 1'b0, '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule